// File: doc/BRIEF.md
# Reduced-pin Ethernet receive to byte-wide receive converter

This block sits between the receive pins of a reduced-pin gigabit PHY link (four data lines plus one control line, all timed by the PHY's receive clock) and a MAC that expects a byte-wide receive stream with separate valid and error flags. The control line is double-pumped. The value seen at the rising edge is data-valid. The value seen at the falling edge is data-valid XOR error. The block therefore recovers the error flag with an XOR of the two samples.

A two-bit speed select picks one of two capture schemes. In gigabit mode, one nibble is taken on each clock edge and both nibbles leave together as one byte per clock. In the 10 and 100 Mb/s modes, only the rising-edge sample is used. Two consecutive nibbles are paired into a byte, and a one-cycle strobe marks each completed byte. All logic runs on the receive clock, with a synchronous active-high reset.

Top module: `rgmii_rx_to_gmii`

## Requirements
- R1: While `rst` is high at a rising edge, all outputs are driven to zero and the nibble pairing phase returns to "expecting the low nibble".
- R2: In gigabit mode, the byte presented is {falling-edge nibble, rising-edge nibble}, so the rising-edge nibble forms bits [3:0]. It appears at the rising edge that follows the falling edge on which the upper nibble was captured.
- R3: In gigabit mode, `gm_rx_dv` equals the control bit taken at the rising edge, and `gm_stb` equals `gm_rx_dv`.
- R4: The error flag equals the falling-edge control bit XOR the rising-edge control bit. It can be high while `gm_rx_dv` is low.
- R5: Speed codes for `spd_sel` are: 2'b10 and 2'b11 select gigabit, 2'b01 selects 100 Mb/s, and 2'b00 selects 10 Mb/s. The two slower codes behave identically.
- R6: In 10/100 mode, the first nibble after data-valid goes high becomes bits [3:0] and the next nibble becomes bits [7:4]. The byte appears one clock after the second nibble is captured, and `gm_stb` is high for exactly that one cycle.
- R7: In 10/100 mode, `gm_rx_dv` rises together with the first byte strobe of a frame. It stays high while data-valid stays high, and it falls one clock after a low data-valid is captured.
- R8: In 10/100 mode, if data-valid drops after only one nibble of a byte, that half byte is discarded with no strobe. The next nibble with data-valid high starts a new byte as bits [3:0].
- R9: In 10/100 mode, `gm_rx_er` is set with a byte strobe when either of that byte's two nibbles carried an error. It is cleared when `gm_rx_dv` falls, and it is never high while `gm_rx_dv` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Receive clock from the PHY |
| rst | input | 1 | Synchronous reset, active high |
| spd_sel | input | 2 | Link speed code (see R5) |
| rxd | input | 4 | Receive data nibble, double-pumped in gigabit mode |
| rx_ctl | input | 1 | Receive control line: valid at rising edge, valid XOR error at falling edge |
| gm_rxd | output | 8 | Assembled receive byte |
| gm_rx_dv | output | 1 | Byte-wide receive data valid |
| gm_rx_er | output | 1 | Byte-wide receive error |
| gm_stb | output | 1 | One pulse per new byte on `gm_rxd` |

## Verification
The block has no parameters, so the bench builds its single fixed configuration with a four-bit nibble and an eight-bit byte. It reaches the different behaviours by driving all four codes on `spd_sel`. This covers both capture schemes, and both slow codes are run through the same nibble sequence to show that they match. Each step drives distinct rising and falling half-cycle values, which exposes nibble order, the XOR error recovery, half-byte abort and reset of the pairing phase.

// File: rtl/rgmii_rx_to_gmii.sv
module rgmii_rx_to_gmii (
  input  logic       rx_clk,
  input  logic       rst,
  input  logic [1:0] spd_sel,
  input  logic [3:0] rxd,
  input  logic       rx_ctl,
  output logic [7:0] gm_rxd,
  output logic       gm_rx_dv,
  output logic       gm_rx_er,
  output logic       gm_stb
);
  localparam int NW = 4;

  logic [NW-1:0] r_nib, f_nib, lo_nib;
  logic          r_ctl, f_ctl, ph, lo_er;
  logic          gig, nib_er;

  assign gig    = spd_sel[1];
  assign nib_er = r_ctl ^ f_ctl;

  always_ff @(posedge rx_clk) begin
    if (rst) begin
      r_nib <= '0;
      r_ctl <= 1'b0;
    end else begin
      r_nib <= rxd;
      r_ctl <= rx_ctl;
    end
  end

  always_ff @(negedge rx_clk) begin
    if (rst) begin
      f_nib <= '0;
      f_ctl <= 1'b0;
    end else begin
      f_nib <= rxd;
      f_ctl <= rx_ctl;
    end
  end

  always_ff @(posedge rx_clk) begin
    if (rst) begin
      gm_rxd   <= '0;
      gm_rx_dv <= 1'b0;
      gm_rx_er <= 1'b0;
      gm_stb   <= 1'b0;
      ph       <= 1'b0;
      lo_nib   <= '0;
      lo_er    <= 1'b0;
    end else if (gig) begin
      gm_rxd   <= {f_nib, r_nib};
      gm_rx_dv <= r_ctl;
      gm_rx_er <= nib_er;
      gm_stb   <= r_ctl;
      ph       <= 1'b0;
      lo_er    <= 1'b0;
    end else if (!r_ctl) begin
      gm_rx_dv <= 1'b0;
      gm_rx_er <= 1'b0;
      gm_stb   <= 1'b0;
      ph       <= 1'b0;
      lo_er    <= 1'b0;
    end else if (!ph) begin
      lo_nib   <= r_nib;
      lo_er    <= nib_er;
      ph       <= 1'b1;
      gm_stb   <= 1'b0;
      gm_rx_er <= gm_rx_er & gm_rx_dv;
    end else begin
      gm_rxd   <= {r_nib, lo_nib};
      gm_rx_dv <= 1'b1;
      gm_rx_er <= lo_er | nib_er;
      gm_stb   <= 1'b1;
      ph       <= 1'b0;
    end
  end
endmodule

module rgmii_rx_to_gmii_chk (
  input logic       rx_clk,
  input logic       rst,
  input logic [1:0] spd_sel,
  input logic [7:0] gm_rxd,
  input logic       gm_rx_dv,
  input logic       gm_rx_er,
  input logic       gm_stb
);
  p_reset_clear_r1: assert property (@(posedge rx_clk)
    rst |=> (gm_rxd == 8'h00 && !gm_rx_dv && !gm_rx_er && !gm_stb));

  p_gig_stb_dv_r3: assert property (@(posedge rx_clk) disable iff (rst)
    $past(spd_sel[1]) |-> (gm_stb == gm_rx_dv));

  p_single_pulse_r6: assert property (@(posedge rx_clk) disable iff (rst)
    (gm_stb && !spd_sel[1]) |=> (spd_sel[1] || !gm_stb));

  p_dv_rise_with_stb_r7: assert property (@(posedge rx_clk) disable iff (rst)
    $rose(gm_rx_dv) |-> gm_stb);

  p_er_needs_dv_r9: assert property (@(posedge rx_clk) disable iff (rst)
    (!$past(spd_sel[1]) && !gm_rx_dv) |-> !gm_rx_er);
endmodule

bind rgmii_rx_to_gmii rgmii_rx_to_gmii_chk chk_i (
  .rx_clk(rx_clk), .rst(rst), .spd_sel(spd_sel), .gm_rxd(gm_rxd),
  .gm_rx_dv(gm_rx_dv), .gm_rx_er(gm_rx_er), .gm_stb(gm_stb)
);

// File: tb/rgmii_rx_to_gmii_tb.sv
`timescale 1ns/1ps
module rgmii_rx_to_gmii_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] spd_sel = 2'b10;
  logic [3:0] rxd = 4'h0;
  logic       rx_ctl = 1'b0;
  logic [7:0] gm_rxd;
  logic       gm_rx_dv, gm_rx_er, gm_stb;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  rgmii_rx_to_gmii dut_i (
    .rx_clk(clk), .rst(rst), .spd_sel(spd_sel), .rxd(rxd), .rx_ctl(rx_ctl),
    .gm_rxd(gm_rxd), .gm_rx_dv(gm_rx_dv), .gm_rx_er(gm_rx_er), .gm_stb(gm_stb)
  );

  task automatic chk(string tag, logic [7:0] ed, logic edv, logic eer, logic estb);
    logic bad;
    n_chk++;
    bad = (gm_rx_dv !== edv) || (gm_rx_er !== eer) || (gm_stb !== estb) ||
          (estb && gm_rxd !== ed);
    if (bad) begin
      n_bad++;
      $display("FAIL %s: got data=%h dv=%b er=%b stb=%b, expected data=%h dv=%b er=%b stb=%b",
               tag, gm_rxd, gm_rx_dv, gm_rx_er, gm_stb, ed, edv, eer, estb);
    end
  endtask

  // outputs seen on return reflect the previous step
  task automatic gstep(logic [7:0] b, logic dv, logic er);
    @(negedge clk); #0.5; rxd = b[3:0]; rx_ctl = dv;
    @(posedge clk); #0.5; rxd = b[7:4]; rx_ctl = dv ^ er;
  endtask

  task automatic nstep(logic [3:0] n, logic dv, logic er);
    @(negedge clk); #0.5; rxd = n; rx_ctl = dv;
    @(posedge clk); #0.5; rx_ctl = dv ^ er;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #0.5;
    chk("R1 reset state", 8'h00, 0, 0, 0);
    if (gm_rxd !== 8'h00) begin
      n_bad++;
      $display("FAIL R1 reset data: got %h expected 00", gm_rxd);
    end
    rst = 1'b0;
  endtask

  task automatic t_gig();
    spd_sel = 2'b10;
    gstep(8'h00, 0, 0);
    gstep(8'h3C, 1, 0);
    gstep(8'hA5, 1, 0);
    chk("R2 R3 gig byte 3C", 8'h3C, 1, 0, 1);
    gstep(8'h00, 0, 0);
    chk("R2 R3 gig byte A5", 8'hA5, 1, 0, 1);
    gstep(8'h00, 0, 0);
    chk("R3 gig idle", 8'h00, 0, 0, 0);
  endtask

  task automatic t_gig_err();
    spd_sel = 2'b11;
    gstep(8'h00, 0, 0);
    gstep(8'h5A, 1, 1);
    gstep(8'h00, 0, 1);
    chk("R4 R5 gig error byte", 8'h5A, 1, 1, 1);
    gstep(8'h00, 0, 0);
    chk("R4 error without valid", 8'h00, 0, 1, 0);
    gstep(8'h00, 0, 0);
    chk("R4 error clears", 8'h00, 0, 0, 0);
  endtask

  task automatic t_slow_pair(logic [1:0] code, string tag);
    spd_sel = code;
    nstep(4'h0, 0, 0);
    nstep(4'h0, 0, 0);
    nstep(4'h5, 1, 0);
    nstep(4'hA, 1, 0);
    chk({tag, " R6 R7 first nibble no strobe"}, 8'h00, 0, 0, 0);
    nstep(4'h3, 1, 0);
    chk({tag, " R6 R7 byte A5"}, 8'hA5, 1, 0, 1);
    nstep(4'hC, 1, 0);
    chk({tag, " R6 strobe one cycle"}, 8'h00, 1, 0, 0);
    nstep(4'h0, 0, 0);
    chk({tag, " R6 byte C3"}, 8'hC3, 1, 0, 1);
    nstep(4'h0, 0, 0);
    chk({tag, " R7 dv falls"}, 8'h00, 0, 0, 0);
  endtask

  task automatic t_abort();
    spd_sel = 2'b01;
    nstep(4'h0, 0, 0);
    nstep(4'h7, 1, 0);
    nstep(4'h0, 0, 0);
    chk("R8 lone nibble no strobe", 8'h00, 0, 0, 0);
    nstep(4'h2, 1, 0);
    chk("R8 drop no strobe", 8'h00, 0, 0, 0);
    nstep(4'h9, 1, 0);
    chk("R8 new low nibble", 8'h00, 0, 0, 0);
    nstep(4'h0, 0, 0);
    chk("R8 restarted byte 92", 8'h92, 1, 0, 1);
    nstep(4'h0, 0, 0);
  endtask

  task automatic t_slow_err();
    spd_sel = 2'b01;
    nstep(4'h0, 0, 0);
    nstep(4'h1, 1, 1);
    nstep(4'h2, 1, 0);
    nstep(4'h0, 0, 1);
    chk("R9 low nibble error", 8'h21, 1, 1, 1);
    nstep(4'h0, 0, 0);
    chk("R9 error cleared with dv", 8'h00, 0, 0, 0);
    nstep(4'h4, 1, 0);
    nstep(4'h8, 1, 1);
    nstep(4'h0, 0, 0);
    chk("R9 high nibble error", 8'h84, 1, 1, 1);
    nstep(4'h0, 0, 0);
  endtask

  task automatic t_reset_mid();
    spd_sel = 2'b01;
    nstep(4'h0, 0, 0);
    nstep(4'h6, 1, 0);
    nstep(4'h7, 1, 0);
    rst = 1'b1;
    @(posedge clk); #0.5;
    chk("R1 reset mid byte", 8'h00, 0, 0, 0);
    rst = 1'b0;
    nstep(4'hB, 1, 0);
    nstep(4'h4, 1, 0);
    nstep(4'h0, 0, 0);
    chk("R1 phase restarted byte 4B", 8'h4B, 1, 0, 1);
    nstep(4'h0, 0, 0);
  endtask

  initial begin
    t_reset();
    t_gig();
    t_gig_err();
    t_slow_pair(2'b01, "R5 100M");
    t_slow_pair(2'b00, "R5 10M");
    t_abort();
    t_slow_err();
    t_reset_mid();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule